// File: doc/BRIEF.md
# Four-Channel Servo Pulse Generator

This block drives four servo outputs from one shared timebase. A prescaler turns the system clock into a 1 MHz tick. A frame counter counts ticks from zero up to a reload value, which sets how often the pulses repeat. Each channel compares the frame count with its own threshold and drives its pin high during the first part of every frame.

Software uses a plain synchronous port to control the block. A write takes one cycle (`cmd_wr` with `cmd_addr` and `cmd_wdata`), and a read is combinational on `rd_addr`. Through this port software sets the frame rate in hertz, sets each pulse width in microseconds, picks which channels may drive, and arms or disarms the outputs.

New widths and a new rate are held in pending registers. They reach the active registers only at the end of a frame, or when software forces an update. Disarming never shortens a pulse: the current frame runs to its end, and then every output rests low.

Top module: `servo_pulse_gen`

## Requirements
- R1: The frame count advances once every CLK_HZ/1,000,000 clock cycles, so the prescale value is that quotient minus one; one frame lasts (reload+1) ticks.
- R2: Writing rate F (1 to 400) to address 0x10 sets the pending reload value to 1,000,000/F − 1 ticks. Reading 0x10 returns the accepted rate, which is 50 after reset (reload 19999).
- R3: A rate write of 0 or above 400 raises `cmd_err` for one cycle, starting in the cycle after the write, and leaves the stored rate unchanged.
- R4: After reset, every output is low and the block is disarmed (status reads 0). Each channel reads back 999, which is a 1000 µs width, and the enable mask at 0x11 reads all ones.
- R5: Writing width N to channel address 0x00+k stores N−1 when N is nonzero and 0 when N is zero. Reading 0x00+k returns the stored pending value. An enabled, running channel is high from the start of a frame for exactly the active stored value in ticks.
- R6: If a channel's active threshold is greater than or equal to the active reload value, that output stays high for the whole frame.
- R7: Width and rate writes made while the frame count runs take effect only when the frame wraps. The frame in progress keeps its width and its length.
- R8: Writing any value to 0x13 forces an update. The frame count restarts at zero and the pending reload and thresholds become active on the same edge.
- R9: The enable mask at 0x11 (bit k enables channel k) takes effect at once. A masked channel's output stays low, and its stored width is kept.
- R10: A write to a channel index of NUM_CH or above, or to a control offset 0x14 to 0x1F, raises `cmd_err` and changes nothing. A read of a missing channel index returns 0.
- R11: Writing 1 in bit 0 of 0x12 arms the block. If the block was stopped, arming also starts a new frame from zero with the pending values loaded. Writing 0 disarms it: the current frame completes, and then counting stops with all outputs low. Reading 0x12 gives armed in bit 0 and running in bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Write strobe, sampled on the rising edge |
| cmd_addr | input | 5 | Write address: 0x00–0x0F channel, 0x10–0x13 control |
| cmd_wdata | input | 16 | Write data |
| cmd_err | output | 1 | One-cycle flag for a rejected write |
| rd_addr | input | 5 | Read address, same map as writes |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| pwm_o | output | NUM_CH | Servo pulse outputs, bit k is channel k |

## Verification
The pulses are tried with several kinds of width:
- mid-range widths on two channels at once, which shows that the channels use separate thresholds on one shared count;
- a zero width, which must give no pulse at all;
- a width longer than the frame, which must give one unbroken high level until the block stops.

A rate change and a width change are written part-way through a frame. The new values must show up one frame later and not in the current frame, which separates shadowed loading from direct loading.

Three control actions are covered:
- A forced update placed between two frame ends must restart the frame and apply the pending width at once.
- A disarm issued while a pulse is high must still let that pulse finish at full length.
- Masked channels with valid widths must stay silent and keep their stored values.

// File: rtl/servo_pwm_pkg.sv
package servo_pwm_pkg;

  localparam int DATA_W         = 16;
  localparam int CNT_W          = 20;
  localparam int ADDR_W         = 5;
  localparam int TICK_HZ        = 1_000_000;
  localparam int MAX_RATE_HZ    = 400;
  localparam int RESET_RATE_HZ  = 50;
  localparam int RESET_WIDTH_US = 1000;

  // control register offsets inside the upper half of the address space
  typedef enum logic [3:0] {
    REG_RATE   = 4'd0,
    REG_MASK   = 4'd1,
    REG_ARM    = 4'd2,
    REG_UPDATE = 4'd3
  } ctl_reg_e;

  // accepted frame rates: 1 Hz up to the ceiling
  function automatic logic rate_ok(input logic [DATA_W-1:0] rate_hz);
    return (rate_hz != '0) && (rate_hz <= DATA_W'(MAX_RATE_HZ));
  endfunction

  // reload value: ticks per frame minus one
  function automatic logic [CNT_W-1:0] period_for_rate(input logic [DATA_W-1:0] rate_hz);
    logic [CNT_W-1:0] ticks;
    if (rate_hz == '0) return '0;
    ticks = CNT_W'(TICK_HZ) / CNT_W'(rate_hz);
    return ticks - 1'b1;
  endfunction

  // microsecond width to stored threshold: N-1, zero stays zero
  function automatic logic [DATA_W-1:0] width_to_cmp(input logic [DATA_W-1:0] width_us);
    return (width_us == '0) ? '0 : width_us - 1'b1;
  endfunction

  // clock cycles per tick (prescale value is this minus one)
  function automatic int unsigned prescale_div(input int unsigned clk_hz);
    return clk_hz / TICK_HZ;
  endfunction

endpackage

// File: rtl/servo_tick_gen.sv
module servo_tick_gen #(
  parameter int unsigned DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic tick
);

  localparam int unsigned TOP = (DIV > 1) ? DIV - 1 : 0;
  localparam int          W   = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV <= 1) begin : g_direct
      // clock already at tick rate: every running cycle is a tick
      logic unused_clear;
      assign unused_clear = clear;
      assign tick = run;
    end else begin : g_div
      logic [W-1:0] psc_q;

      always_ff @(posedge clk) begin
        if (!rst_n)          psc_q <= '0;
        else if (clear)      psc_q <= '0;
        else if (run)        psc_q <= (psc_q == W'(TOP)) ? '0 : psc_q + 1'b1;
      end

      assign tick = run && (psc_q == W'(TOP));

      // R1: with a divider of two or more, ticks never come back to back
      a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/servo_frame_ctr.sv
module servo_frame_ctr
  import servo_pwm_pkg::*;
#(
  parameter logic [CNT_W-1:0] RESET_PER = 20'd19999
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             arm_set,
  input  logic             arm_clr,
  input  logic             force_upd,
  input  logic [CNT_W-1:0] per_pend,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] per_act,
  output logic             running,
  output logic             armed,
  output logic             wrap,
  output logic             restart,
  output logic             upd_evt
);

  logic armed_d;

  always_comb begin
    armed_d = armed;
    if (arm_set)      armed_d = 1'b1;
    else if (arm_clr) armed_d = 1'b0;
  end

  // restart: forced update, or arming a stopped counter
  assign restart = force_upd || (arm_set && !running);
  assign wrap    = running && tick && (cnt == per_act) && !restart;
  assign upd_evt = restart || wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      per_act <= RESET_PER;
      running <= 1'b0;
      armed   <= 1'b0;
    end else begin
      armed <= armed_d;
      if (restart) begin
        cnt     <= '0;
        per_act <= per_pend;
        if (arm_set) running <= 1'b1;
      end else if (wrap) begin
        cnt     <= '0;
        per_act <= per_pend;
        if (!armed_d) running <= 1'b0;
      end else if (running && tick) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R11: a running counter stops only at a frame end
  a_r11_finish_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !wrap) |=> running);

  // R2: the count never passes the active reload
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt <= per_act));

  // R8: a forced update leaves the count at zero
  a_r8_force_zero: assert property (@(posedge clk) disable iff (!rst_n)
    force_upd |=> (cnt == '0));

  // R7: the active reload only moves on an update event
  a_r7_per_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_evt |=> $stable(per_act));

endmodule

// File: rtl/servo_chan.sv
module servo_chan
  import servo_pwm_pkg::*;
#(
  parameter logic [DATA_W-1:0] RESET_CMP = 16'd999
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_width,
  input  logic              upd,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  per_act,
  input  logic              running,
  input  logic              enable,
  output logic [DATA_W-1:0] cmp_pend,
  output logic              pwm
);

  logic [DATA_W-1:0] cmp_act;
  logic [CNT_W-1:0]  cmp_ext;
  logic              below, saturate;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_pend <= RESET_CMP;
      cmp_act  <= RESET_CMP;
    end else begin
      if (wr_en) cmp_pend <= width_to_cmp(wr_width);
      if (upd)   cmp_act  <= cmp_pend;
    end
  end

  assign cmp_ext  = CNT_W'(cmp_act);
  assign below    = cnt < cmp_ext;
  assign saturate = cmp_ext >= per_act;
  assign pwm      = running && enable && (below || saturate);

  // R7: the active threshold only moves on an update event
  a_r7_cmp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(cmp_act));

  // R6: a threshold at or past the reload keeps an enabled pin high
  a_r6_full_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (running && enable && saturate) |-> pwm);

endmodule

// File: rtl/servo_pulse_gen.sv
module servo_pulse_gen
  import servo_pwm_pkg::*;
#(
  parameter int unsigned CLK_HZ = 100_000_000,
  parameter int          NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [4:0]        cmd_addr,
  input  logic [15:0]       cmd_wdata,
  output logic              cmd_err,
  input  logic [4:0]        rd_addr,
  output logic [15:0]       rd_data,
  output logic [NUM_CH-1:0] pwm_o
);

  localparam int unsigned      PSC_DIV   = prescale_div(CLK_HZ);
  localparam logic [CNT_W-1:0] RESET_PER = period_for_rate(DATA_W'(RESET_RATE_HZ));
  localparam logic [DATA_W-1:0] RESET_CMP = width_to_cmp(DATA_W'(RESET_WIDTH_US));

  // ---------------- write decode ----------------
  logic              is_ch, ch_ok, ctl_ok;
  logic              rate_we, mask_we, arm_set, arm_clr, force_upd, wr_bad;
  logic [3:0]        sub;

  assign is_ch  = !cmd_addr[4];
  assign sub    = cmd_addr[3:0];
  assign ch_ok  = int'(sub) < NUM_CH;
  assign ctl_ok = (sub == REG_RATE) || (sub == REG_MASK) ||
                  (sub == REG_ARM)  || (sub == REG_UPDATE);

  always_comb begin
    rate_we   = 1'b0;
    mask_we   = 1'b0;
    arm_set   = 1'b0;
    arm_clr   = 1'b0;
    force_upd = 1'b0;
    wr_bad    = 1'b0;
    if (cmd_wr) begin
      if (is_ch) begin
        wr_bad = !ch_ok;
      end else if (!ctl_ok) begin
        wr_bad = 1'b1;
      end else begin
        case (sub)
          REG_RATE: begin
            if (rate_ok(cmd_wdata)) rate_we = 1'b1;
            else                    wr_bad  = 1'b1;
          end
          REG_MASK:   mask_we   = 1'b1;
          REG_ARM: begin
            arm_set = cmd_wdata[0];
            arm_clr = !cmd_wdata[0];
          end
          REG_UPDATE: force_upd = 1'b1;
          default:    wr_bad    = 1'b1;
        endcase
      end
    end
  end

  // ---------------- control registers ----------------
  logic [DATA_W-1:0] rate_q;
  logic [CNT_W-1:0]  per_pend;
  logic [NUM_CH-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_q   <= DATA_W'(RESET_RATE_HZ);
      per_pend <= RESET_PER;
      mask_q   <= '1;
      cmd_err  <= 1'b0;
    end else begin
      cmd_err <= wr_bad;
      if (rate_we) begin
        rate_q   <= cmd_wdata;
        per_pend <= period_for_rate(cmd_wdata);
      end
      if (mask_we) mask_q <= cmd_wdata[NUM_CH-1:0];
    end
  end

  // ---------------- timebase ----------------
  logic             tick, running, armed, wrap, restart, upd_evt;
  logic [CNT_W-1:0] cnt, per_act;

  servo_tick_gen #(.DIV(PSC_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (restart),
    .run   (running),
    .tick  (tick)
  );

  servo_frame_ctr #(.RESET_PER(RESET_PER)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .arm_set   (arm_set),
    .arm_clr   (arm_clr),
    .force_upd (force_upd),
    .per_pend  (per_pend),
    .cnt       (cnt),
    .per_act   (per_act),
    .running   (running),
    .armed     (armed),
    .wrap      (wrap),
    .restart   (restart),
    .upd_evt   (upd_evt)
  );

  // ---------------- channels ----------------
  logic [DATA_W-1:0] cmp_pend [NUM_CH];

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic ch_we;
      assign ch_we = cmd_wr && is_ch && (sub == 4'(i));

      servo_chan #(.RESET_CMP(RESET_CMP)) u_chan (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ch_we),
        .wr_width (cmd_wdata),
        .upd      (upd_evt),
        .cnt      (cnt),
        .per_act  (per_act),
        .running  (running),
        .enable   (mask_q[i]),
        .cmp_pend (cmp_pend[i]),
        .pwm      (pwm_o[i])
      );
    end
  endgenerate

  // ---------------- read mux ----------------
  always_comb begin
    rd_data = '0;
    if (!rd_addr[4]) begin
      for (int k = 0; k < NUM_CH; k++)
        if (rd_addr[3:0] == 4'(k)) rd_data = cmp_pend[k];
    end else begin
      case (rd_addr[3:0])
        REG_RATE: rd_data = rate_q;
        REG_MASK: rd_data = DATA_W'(mask_q);
        REG_ARM:  rd_data = {{(DATA_W-2){1'b0}}, running, armed};
        default:  rd_data = '0;
      endcase
    end
  end

  // R3, R10: an error flag always follows a write strobe
  a_r3_err_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $past(cmd_wr));

  // R11: a stopped block drives nothing
  a_r11_stopped_low: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (pwm_o == '0));

  // R9: masked channels never drive
  a_r9_mask_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_o & ~mask_q) == '0);

  // R1: the frame count only moves on a tick or an update event
  a_r1_count_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !upd_evt) |=> $stable(cnt));

endmodule

// File: tb/servo_pulse_gen_bench.sv
module servo_pulse_gen_bench;

  localparam int NCH  = 4;
  localparam int CLKF = 2_000_000;        // two cycles per 1 MHz tick
  localparam int TPC  = CLKF / 1_000_000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [4:0]  cmd_addr = '0;
  logic [15:0] cmd_wdata = '0;
  logic        cmd_err;
  logic [4:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [NCH-1:0] pwm;

  servo_pulse_gen #(.CLK_HZ(CLKF), .NUM_CH(NCH)) u_servo_pulse_gen (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .cmd_err(cmd_err), .rd_addr(rd_addr),
    .rd_data(rd_data), .pwm_o(pwm)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails  = 0;
  int seq_id = 0;

  typedef struct { int len; string req; } exp_t;
  exp_t q0[$], q1[$], q2[$], q3[$], qp[$];

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  // expected high time in cycles for a stored threshold
  function automatic int hi_cycles(input int stored);
    return stored * TPC;
  endfunction

  task automatic push_pulse(input int ch, input int len, input string req);
    exp_t e;
    e.len = len; e.req = req;
    case (ch)
      0: q0.push_back(e);
      1: q1.push_back(e);
      2: q2.push_back(e);
      default: q3.push_back(e);
    endcase
  endtask

  task automatic take_pulse(input int ch, input int len);
    exp_t e;
    int   n;
    case (ch)
      0: n = q0.size();
      1: n = q1.size();
      2: n = q2.size();
      default: n = q3.size();
    endcase
    if (n == 0) begin
      checks++; fails++;
      $display("FAIL R9 unexpected pulse on ch%0d got %0d expected none", ch, len);
    end else begin
      case (ch)
        0: e = q0.pop_front();
        1: e = q1.pop_front();
        2: e = q2.pop_front();
        default: e = q3.pop_front();
      endcase
      check(e.req, len, e.len);
    end
  endtask

  task automatic take_interval(input int len);
    exp_t e;
    if (qp.size() == 0) begin
      checks++; fails++;
      $display("FAIL R2 unexpected frame start got %0d expected none", len);
    end else begin
      e = qp.pop_front();
      check(e.req, len, e.len);
    end
  endtask

  // ---------------- monitor ----------------
  int       hi_len [NCH];
  logic [NCH-1:0] prev = '0;
  int       last_rise = 0;
  int       rise_seq  = -1;

  initial for (int i = 0; i < NCH; i++) hi_len[i] = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        if (pwm[i]) hi_len[i]++;
        else if (hi_len[i] != 0) begin
          take_pulse(i, hi_len[i]);
          hi_len[i] = 0;
        end
      end
      if (pwm[0] && !prev[0]) begin
        if (rise_seq == seq_id) take_interval(cyc - last_rise);
        rise_seq  = seq_id;
        last_rise = cyc;
      end
      prev = pwm;
    end
  end

  // ---------------- driver ----------------
  task automatic wr(input logic [4:0] a, input int d, output int stamp);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_addr = a; cmd_wdata = 16'(d); stamp = cyc;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic wr_chk(input logic [4:0] a, input int d, input int exp_err, input string req);
    int s;
    wr(a, d, s);
    check(req, int'(cmd_err), exp_err);
  endtask

  task automatic rd_chk(input logic [4:0] a, input int exp, input string req);
    @(negedge clk);
    rd_addr = a;
    #1;
    check(req, int'(rd_data), exp);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drained(input string req);
    check({req, " ch0 leftover"}, q0.size(), 0);
    check({req, " ch1 leftover"}, q1.size(), 0);
    check({req, " ch2 leftover"}, q2.size(), 0);
    check({req, " ch3 leftover"}, q3.size(), 0);
    check({req, " frame leftover"}, qp.size(), 0);
    check({req, " outputs low"}, int'(pwm), 0);
  endtask

  logic done = 1'b0;

  initial begin
    int sa, sf, s;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(2);

    // R4 reset state
    check("R4 outputs", int'(pwm), 0);
    for (int k = 0; k < NCH; k++) rd_chk(5'(k), 999, "R4 width");
    rd_chk(5'h10, 50, "R4 rate");
    rd_chk(5'h11, 15, "R4 mask");
    rd_chk(5'h12, 0, "R4 status");

    // R3 rejected rates, R2 accepted rate
    wr_chk(5'h10, 401, 1, "R3 rate 401");
    wr_chk(5'h10, 0, 1, "R3 rate 0");
    rd_chk(5'h10, 50, "R3 rate kept");
    wr_chk(5'h10, 400, 0, "R2 rate 400");
    rd_chk(5'h10, 400, "R2 rate read");

    // R10 bad indices
    wr_chk(5'h04, 1234, 1, "R10 ch4");
    wr_chk(5'h09, 1234, 1, "R10 ch9");
    wr_chk(5'h15, 1, 1, "R10 ctl 0x15");
    rd_chk(5'h09, 0, "R10 read ch9");
    rd_chk(5'h04, 0, "R10 read ch4");

    // R5 storage
    wr_chk(5'h00, 1500, 0, "R5 write");
    rd_chk(5'h00, 1499, "R5 minus one");
    wr(5'h00, 0, s);
    rd_chk(5'h00, 0, "R5 zero");
    wr(5'h00, 1, s);
    rd_chk(5'h00, 0, "R5 one");

    // Seq A: R1 R2 R5 R11 two channels, disarm mid pulse
    seq_id++;
    wr(5'h00, 1000, s);
    wr(5'h01, 1501, s);
    wr(5'h11, 3, s);
    for (int f = 0; f < 3; f++) begin
      push_pulse(0, hi_cycles(999), "R5 ch0 width");
      push_pulse(1, hi_cycles(1500), "R5 ch1 width");
    end
    push_pulse(-1, 0, "") ; // placeholder removed below
    void'(q3.pop_back());
    qp.push_back('{2500 * TPC, "R1 frame length"});
    qp.push_back('{2500 * TPC, "R2 frame length"});
    wr(5'h12, 1, sa);
    rd_chk(5'h12, 3, "R11 armed running");
    wait_cyc(10496);
    wr(5'h12, 0, s);
    rd_chk(5'h12, 2, "R11 disarmed still running");
    wait_cyc(5600);
    rd_chk(5'h12, 0, "R11 stopped");
    drained("R11");

    // Seq B: R7 mid-frame width and rate change
    seq_id++;
    wr(5'h11, 1, s);
    push_pulse(0, hi_cycles(999), "R7 old width kept");
    push_pulse(0, hi_cycles(2000), "R7 new width");
    push_pulse(0, hi_cycles(2000), "R7 new width again");
    qp.push_back('{2500 * TPC, "R7 old frame kept"});
    qp.push_back('{5000 * TPC, "R7 new frame length"});
    wr(5'h12, 1, sa);
    wait_cyc(96);
    wr(5'h00, 2001, s);
    rd_chk(5'h00, 2000, "R5 readback pending");
    wr(5'h10, 200, s);
    wait_cyc(15700);
    wr(5'h12, 0, s);
    wait_cyc(9500);
    drained("R7");

    // Seq C: R6 saturated width, R9 mask, R5 zero width
    seq_id++;
    wr(5'h10, 400, s);
    wr(5'h01, 0, s);
    wr(5'h02, 3000, s);
    wr(5'h03, 1234, s);
    wr(5'h11, 6, s);
    push_pulse(2, 2500 * TPC, "R6 whole frame");
    wr(5'h12, 1, sa);
    wait_cyc(50);
    check("R9 only ch2 high", int'(pwm), 4);
    wr(5'h12, 0, s);
    wait_cyc(5200);
    rd_chk(5'h03, 1233, "R9 width kept");
    rd_chk(5'h01, 0, "R5 zero kept");
    drained("R9");

    // Seq D: R8 forced update mid frame
    seq_id++;
    wr(5'h00, 1000, s);
    wr(5'h11, 1, s);
    push_pulse(0, hi_cycles(999), "R8 first width");
    push_pulse(0, hi_cycles(1200), "R8 pending loaded");
    wr(5'h12, 1, sa);
    wait_cyc(2497);
    wr(5'h00, 1201, s);
    wait_cyc(497);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_addr = 5'h13; cmd_wdata = 16'd0;
    sf = cyc;
    qp.push_back('{sf - sa, "R8 restart point"});
    @(negedge clk);
    cmd_wr = 1'b0;
    wait_cyc(400);
    wr(5'h12, 0, s);
    wait_cyc(5500);
    drained("R8");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  // watchdog
  always @(negedge clk) begin
    if (!done && cyc >= 150000) begin
      checks++; fails++;
      $display("FAIL watchdog got %0d expected finish", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule